// File: doc/BRIEF.md
# Timebase Counter Register Block

This peripheral sits on a plain 32-bit register bus. The bus carries a byte address, a write strobe, write data and combinational read data. Software can read and preset three counters through it. Two of them follow wall-clock time: one steps once per second and one steps once per hundredth of a second. Each of these is paced by a free-running divider whose terminal count comes from the `CLK_HZ` parameter. The third counter counts prescaled clock cycles. A 32-bit down-counter drives it. The down-counter reloads itself from a software-set value and can be read live or overwritten.

The block also holds a two-bit LED output register and a synchronised two-bit button input. A ten-bit control register drives individual pins: display chip-select, reset, register-select, read strobe and backlight, one slave-select, and three chip-selects. Its bit 2 is unused. The asynchronous active-low reset passes through an internal synchroniser, so its release is synchronous to the clock. Read data follows the address within the same cycle.

Top module: `tbase_periph`

## Requirements
- R1: While reset is held, every mapped register reads zero, and the LED and control pins are all low.
- R2: Offset 0x000 stores write-data bits [1:0], which drive `led_o` from the next cycle. Bits [31:2] read zero.
- R3: Offset 0x04C stores write-data bits [9:0] except bit 2. Bit 2 and bits [31:10] read zero. Stored bits 0, 1, 3, 4, 5, 6, 7, 8 and 9 drive `disp_cs_o`, `ss_n_o`, `disp_rst_o`, `disp_rs_o`, `disp_rd_o`, `disp_bl_o`, `cs0_n_o`, `cs1_n_o` and `cs2_n_o` respectively.
- R4: Any offset other than 0x000, 0x008, 0x010, 0x014, 0x018, 0x020, 0x024 and 0x04C reads zero. A write to such an offset changes no register.
- R5: Offset 0x008 returns `btn_i` in bits [1:0] after two flip-flop stages, with bits [31:2] zero. A new input value shows in the read on the second rising edge after it is applied. Writes to this offset are ignored.
- R6: The counter at 0x014 adds one exactly once every `CLK_HZ/100` clock cycles.
- R7: The counter at 0x010 adds one exactly once every `CLK_HZ` clock cycles.
- R8: The live prescaler at 0x024 decrements by one per cycle. In a cycle where it is zero, it loads the reload value held at 0x020. Both registers read back and accept writes.
- R9: The cycle counter at 0x018 adds one in each cycle that the live prescaler is zero. With reload value N, it therefore steps once every N+1 cycles, and every cycle when N is 0.
- R10: Every counter, the reload value and the live prescaler take a written value on the next edge. A write that lands in the same cycle as an internal increment wins.
- R11: Writing a tick counter does not disturb its divider, so the next tick keeps the phase it had before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Byte address, word aligned |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| btn_i | input | 2 | Raw button inputs |
| led_o | output | 2 | LED drive |
| disp_cs_o | output | 1 | Display chip-select (control bit 0) |
| ss_n_o | output | 1 | Slave-select (control bit 1) |
| disp_rst_o | output | 1 | Display reset (control bit 3) |
| disp_rs_o | output | 1 | Display register-select (control bit 4) |
| disp_rd_o | output | 1 | Display read strobe (control bit 5) |
| disp_bl_o | output | 1 | Display backlight (control bit 6) |
| cs0_n_o | output | 1 | Converter chip-select (control bit 7) |
| cs1_n_o | output | 1 | Expansion chip-select 0 (control bit 8) |
| cs2_n_o | output | 1 | Expansion chip-select 1 (control bit 9) |

## Verification
The bench writes a tick counter a few cycles after an observed tick and checks that the next step arrives on the old phase. A design that restarted the divider on a write would step three cycles late.

It writes the cycle counter while that counter increments every cycle. If the increment won over the write, the read-back would be off by one. The bench also checks the prescaler's zero-and-reload step: an off-by-one period or a reload taken one cycle late would show as a wrong live value or a wrong count over a window of several periods.

Reserved control bit 2, unmapped offsets and writes to the button register are all checked through the read port. A design that stored any of them would read back non-zero.

// File: rtl/tbase_pkg.sv
`timescale 1ns/1ps
package tbase_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned LED_W = 2;
  localparam int unsigned BTN_W = 2;
  localparam int unsigned CTL_W = 10;
  localparam logic [CTL_W-1:0] CTL_MASK = 10'h3FB;

  // byte offsets of the mapped registers
  localparam logic [11:0] OFS_LED  = 12'h000;
  localparam logic [11:0] OFS_BTN  = 12'h008;
  localparam logic [11:0] OFS_SLOW = 12'h010;
  localparam logic [11:0] OFS_FAST = 12'h014;
  localparam logic [11:0] OFS_CYC  = 12'h018;
  localparam logic [11:0] OFS_RLD  = 12'h020;
  localparam logic [11:0] OFS_PSC  = 12'h024;
  localparam logic [11:0] OFS_CTL  = 12'h04C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LED, SEL_BTN, SEL_SLOW, SEL_FAST,
    SEL_CYC, SEL_RLD, SEL_PSC, SEL_CTL
  } reg_sel_e;

  function automatic logic [29:0] word_of(logic [11:0] ofs);
    return 30'(ofs >> 2);
  endfunction

  function automatic reg_sel_e decode(logic [29:0] word);
    reg_sel_e s;
    s = SEL_NONE;
    if (word == word_of(OFS_LED))  s = SEL_LED;
    if (word == word_of(OFS_BTN))  s = SEL_BTN;
    if (word == word_of(OFS_SLOW)) s = SEL_SLOW;
    if (word == word_of(OFS_FAST)) s = SEL_FAST;
    if (word == word_of(OFS_CYC))  s = SEL_CYC;
    if (word == word_of(OFS_RLD))  s = SEL_RLD;
    if (word == word_of(OFS_PSC))  s = SEL_PSC;
    if (word == word_of(OFS_CTL))  s = SEL_CTL;
    return s;
  endfunction
endpackage

// File: rtl/tbase_sync2.sv
`timescale 1ns/1ps
module tbase_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/tbase_tick_div.sv
`timescale 1ns/1ps
module tbase_tick_div #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = tick;
endmodule

// File: rtl/tbase_wr_cnt.sv
`timescale 1ns/1ps
module tbase_wr_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  always_comb begin
    en    = wr_i | inc_i;
    cnt_d = wr_i ? wdata_i : cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (en)  cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tbase_prescaler.sv
`timescale 1ns/1ps
module tbase_prescaler #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_rld_i,
  input  logic         wr_val_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rld_o,
  output logic [W-1:0] val_o,
  output logic         zero_o
);
  logic [W-1:0] rld_q, val_q, val_d;
  logic         zero;

  always_comb begin
    zero = (val_q == '0);
    if (wr_val_i)  val_d = wdata_i;
    else if (zero) val_d = rld_q;
    else           val_d = val_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rld_q <= '0;
    else if (wr_rld_i) rld_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign rld_o  = rld_q;
  assign val_o  = val_q;
  assign zero_o = zero;
endmodule

// File: rtl/tbase_periph.sv
`timescale 1ns/1ps
module tbase_periph
  import tbase_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [1:0]        btn_i,
  output logic [1:0]        led_o,
  output logic              disp_cs_o,
  output logic              ss_n_o,
  output logic              disp_rst_o,
  output logic              disp_rs_o,
  output logic              disp_rd_o,
  output logic              disp_bl_o,
  output logic              cs0_n_o,
  output logic              cs1_n_o,
  output logic              cs2_n_o
);
  localparam int unsigned NTICK = 2;
  localparam int unsigned DIVS [NTICK] = '{CLK_HZ, CLK_HZ / 100};

  logic rst_sync_n;
  tbase_sync2 #(.W(1)) rst_sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_sync_n)
  );

  // address decode
  reg_sel_e sel;
  logic     wr_led, wr_ctl, wr_cyc, wr_psc, wr_rld, rd_btn;
  logic [NTICK-1:0] wr_tick;

  always_comb begin
    sel     = decode(30'(bus_addr_i[ADDR_W-1:2]));
    wr_led  = bus_we_i && (sel == SEL_LED);
    wr_ctl  = bus_we_i && (sel == SEL_CTL);
    wr_cyc  = bus_we_i && (sel == SEL_CYC);
    wr_psc  = bus_we_i && (sel == SEL_PSC);
    wr_rld  = bus_we_i && (sel == SEL_RLD);
    wr_tick = {bus_we_i && (sel == SEL_FAST), bus_we_i && (sel == SEL_SLOW)};
    rd_btn  = (sel == SEL_BTN);
  end

  // LED and control registers
  logic [LED_W-1:0] led_q, led_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;

  always_comb begin
    led_d = bus_wdata_i[LED_W-1:0];
    ctl_d = bus_wdata_i[CTL_W-1:0] & CTL_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  led_q <= '0;
    else if (wr_led)  led_q <= led_d;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctl_q <= '0;
    else if (wr_ctl)  ctl_q <= ctl_d;
  end

  // button synchroniser
  logic [BTN_W-1:0] btn_s;
  tbase_sync2 #(.W(BTN_W)) btn_sync_i (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .d_i(btn_i), .q_o(btn_s)
  );

  // wall-clock tick counters
  logic [REG_W-1:0] tick_cnt [NTICK];
  for (genvar g = 0; g < NTICK; g++) begin : g_tick
    logic tick;
    tbase_tick_div #(.DIV(DIVS[g])) div_i (
      .clk_i(clk_i), .rst_ni(rst_sync_n), .tick_o(tick)
    );
    tbase_wr_cnt #(.W(REG_W)) cnt_i (
      .clk_i(clk_i), .rst_ni(rst_sync_n), .inc_i(tick),
      .wr_i(wr_tick[g]), .wdata_i(bus_wdata_i), .cnt_o(tick_cnt[g])
    );
  end

  // prescaler and cycle counter
  logic [REG_W-1:0] rld_val, psc_val, cyc_val;
  logic             psc_zero;

  tbase_prescaler #(.W(REG_W)) psc_i (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .wr_rld_i(wr_rld), .wr_val_i(wr_psc),
    .wdata_i(bus_wdata_i), .rld_o(rld_val), .val_o(psc_val), .zero_o(psc_zero)
  );

  tbase_wr_cnt #(.W(REG_W)) cyc_i (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .inc_i(psc_zero),
    .wr_i(wr_cyc), .wdata_i(bus_wdata_i), .cnt_o(cyc_val)
  );

  // read mux
  always_comb begin
    case (sel)
      SEL_LED:  bus_rdata_o = REG_W'(led_q);
      SEL_BTN:  bus_rdata_o = REG_W'(btn_s);
      SEL_SLOW: bus_rdata_o = tick_cnt[0];
      SEL_FAST: bus_rdata_o = tick_cnt[1];
      SEL_CYC:  bus_rdata_o = cyc_val;
      SEL_RLD:  bus_rdata_o = rld_val;
      SEL_PSC:  bus_rdata_o = psc_val;
      SEL_CTL:  bus_rdata_o = REG_W'(ctl_q);
      default:  bus_rdata_o = '0;
    endcase
  end

  logic [CTL_W-1:0] ctl_pins;
  assign led_o      = led_q;
  assign disp_cs_o  = ctl_q[0];
  assign ss_n_o     = ctl_q[1];
  assign disp_rst_o = ctl_q[3];
  assign disp_rs_o  = ctl_q[4];
  assign disp_rd_o  = ctl_q[5];
  assign disp_bl_o  = ctl_q[6];
  assign cs0_n_o    = ctl_q[7];
  assign cs1_n_o    = ctl_q[8];
  assign cs2_n_o    = ctl_q[9];
  assign ctl_pins   = {cs2_n_o, cs1_n_o, cs0_n_o, disp_bl_o, disp_rd_o,
                       disp_rs_o, disp_rst_o, 1'b0, ss_n_o, disp_cs_o};
endmodule

// File: rtl/tbase_periph_chk.sv
`timescale 1ns/1ps
module tbase_periph_chk (
  input logic        clk_i,
  input logic        rst_n,
  input logic [31:0] wdata,
  input logic        wr_led,
  input logic        wr_ctl,
  input logic        wr_cyc,
  input logic        wr_psc,
  input logic        rd_btn,
  input logic [31:0] psc_val,
  input logic [31:0] rld_val,
  input logic [31:0] cyc_val,
  input logic [1:0]  led_o,
  input logic [9:0]  ctl_pins,
  input logic [31:0] rdata
);
  // R2
  led_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_led |=> led_o == $past(wdata[1:0]));
  // R3
  ctl_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_ctl |=> ctl_pins == ($past(wdata[9:0]) & 10'h3FB));
  // R5
  btn_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_btn |-> rdata[31:2] == 30'd0);
  // R8
  psc_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!wr_psc && psc_val != 32'd0) |=> psc_val == $past(psc_val) - 32'd1);
  // R8
  psc_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!wr_psc && psc_val == 32'd0) |=> psc_val == $past(rld_val));
  // R9
  cyc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!wr_cyc && psc_val == 32'd0) |=> cyc_val == $past(cyc_val) + 32'd1);
  // R9
  cyc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!wr_cyc && psc_val != 32'd0) |=> $stable(cyc_val));
  // R10
  cyc_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_cyc |=> cyc_val == $past(wdata));
endmodule

bind tbase_periph tbase_periph_chk chk_i (
  .clk_i(clk_i), .rst_n(rst_sync_n), .wdata(bus_wdata_i),
  .wr_led(wr_led), .wr_ctl(wr_ctl), .wr_cyc(wr_cyc), .wr_psc(wr_psc),
  .rd_btn(rd_btn), .psc_val(psc_val), .rld_val(rld_val), .cyc_val(cyc_val),
  .led_o(led_o), .ctl_pins(ctl_pins), .rdata(bus_rdata_o)
);

// File: tb/tbase_periph_tb_top.sv
`timescale 1ns/1ps
module tbase_periph_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic [1:0]  btn = '0;
  logic [1:0]  led;
  logic        p_cs, p_ss, p_rst, p_rs, p_rd, p_bl, p_c0, p_c1, p_c2;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tbase_periph #(.CLK_HZ(1000), .ADDR_W(12)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wd), .bus_rdata_o(rdata), .btn_i(btn), .led_o(led),
    .disp_cs_o(p_cs), .ss_n_o(p_ss), .disp_rst_o(p_rst), .disp_rs_o(p_rs),
    .disp_rd_o(p_rd), .disp_bl_o(p_bl), .cs0_n_o(p_c0), .cs1_n_o(p_c1),
    .cs2_n_o(p_c2)
  );

  typedef struct packed {
    logic [11:0] a;
    logic        w;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  r;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{12'h000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0003, 8'd2},  // R2 upper bits dropped
    '{12'h000, 1'b1, 32'h0000_0002, 32'h0000_0002, 8'd2},  // R2
    '{12'h04C, 1'b1, 32'hFFFF_FFFF, 32'h0000_03FB, 8'd3},  // R3 bit 2 reserved
    '{12'h04C, 1'b1, 32'h0000_0004, 32'h0000_0000, 8'd3},  // R3
    '{12'h04C, 1'b1, 32'h0000_02A1, 32'h0000_02A1, 8'd3},  // R3
    '{12'h004, 1'b1, 32'h0000_DEAD, 32'h0000_0000, 8'd4},  // R4
    '{12'h01C, 1'b1, 32'h1234_5678, 32'h0000_0000, 8'd4},  // R4
    '{12'h800, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'd4},  // R4
    '{12'h000, 1'b0, 32'h0000_0000, 32'h0000_0002, 8'd4},  // R4 LED undisturbed
    '{12'h04C, 1'b0, 32'h0000_0000, 32'h0000_02A1, 8'd4},  // R4 control undisturbed
    '{12'h020, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd8},  // R8 reload readback
    '{12'h008, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'd5}   // R5 write ignored
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // call at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wd = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    addr = a;
    #0.2;
    v = rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a0, b0;
    // R1 reset state
    #12;
    rd(12'h000, v); chk("R1 led reg", v, 0);
    rd(12'h010, v); chk("R1 slow cnt", v, 0);
    rd(12'h014, v); chk("R1 fast cnt", v, 0);
    rd(12'h018, v); chk("R1 cycle cnt", v, 0);
    rd(12'h020, v); chk("R1 reload", v, 0);
    rd(12'h024, v); chk("R1 prescaler", v, 0);
    rd(12'h04C, v); chk("R1 control", v, 0);
    chk("R1 pins", {22'd0, p_c2, p_c1, p_c0, p_bl, p_rd, p_rs, p_rst, p_ss, p_cs, led}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    edges(3);

    // table walk
    for (int i = 0; i < NV; i++) begin
      addr = VECS[i].a; wd = VECS[i].d; we = VECS[i].w;
      if (VECS[i].w) begin
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
      end
      #0.2;
      chk($sformatf("R%0d vector %0d", VECS[i].r, i), rdata, VECS[i].e);
    end
    @(negedge clk);

    // R3 pin mapping for control value 0x2A1, R2 LED pins
    chk("R3 pins", {22'd0, p_c2, p_c1, p_c0, p_bl, p_rd, p_rs, p_rst, 1'b0, p_ss, p_cs}, 32'h2A1);
    chk("R2 led pins", {30'd0, led}, 32'h2);

    // R5 two-stage synchroniser latency
    btn = 2'b10;
    edges(1); rd(12'h008, v); chk("R5 after one edge", v, 0);
    edges(1); rd(12'h008, v); chk("R5 after two edges", v, 32'h2);

    // R8 live prescaler with reload 0xFFFFFFFF
    wr(12'h024, 32'd100); rd(12'h024, v); chk("R8 psc write", v, 100);
    edges(7); rd(12'h024, v); chk("R8 psc decrement", v, 93);
    wr(12'h024, 32'd2); rd(12'h018, a0);
    edges(2); rd(12'h024, v); chk("R8 psc at zero", v, 0);
    rd(12'h018, v); chk("R9 no step before zero", v, a0);
    edges(1); rd(12'h024, v); chk("R8 psc reloaded", v, 32'hFFFF_FFFF);
    rd(12'h018, v); chk("R9 step on zero", v, a0 + 1);

    // R9 period reload+1
    wr(12'h020, 32'd4); wr(12'h024, 32'd0);
    rd(12'h018, a0); edges(50); rd(12'h018, b0);
    chk("R9 reload 4 window", b0 - a0, 10);
    wr(12'h020, 32'd0); wr(12'h024, 32'd0);
    rd(12'h018, a0); edges(37); rd(12'h018, b0);
    chk("R9 reload 0 window", b0 - a0, 37);

    // R10 write wins over per-cycle increment
    wr(12'h018, 32'h1234); rd(12'h018, v); chk("R10 write wins", v, 32'h1234);
    edges(1); rd(12'h018, v); chk("R10 resumes", v, 32'h1235);
    wr(12'h010, 32'hAB); rd(12'h010, v); chk("R10 slow preset", v, 32'hAB);
    wr(12'h014, 32'd7); rd(12'h014, v); chk("R10 fast preset", v, 7);

    // R6 / R7 rates
    rd(12'h014, a0); edges(250); rd(12'h014, b0); chk("R6 fast rate", b0 - a0, 25);
    rd(12'h010, a0); edges(3000); rd(12'h010, b0); chk("R7 slow rate", b0 - a0, 3);

    // R11 divider phase kept across a write
    rd(12'h014, a0);
    for (int k = 0; k < 20; k++) begin
      edges(1); rd(12'h014, b0);
      if (b0 != a0) break;
      a0 = b0;
    end
    edges(2);
    wr(12'h014, 32'd50); rd(12'h014, v); chk("R11 written", v, 50);
    edges(6); rd(12'h014, v); chk("R11 no early tick", v, 50);
    edges(1); rd(12'h014, v); chk("R11 tick on old phase", v, 51);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule